// File: doc/BRIEF.md
# Interrupt Pending and Enable Controller

This block gathers single-cycle interrupt requests from a set of peripheral sources into a pending-flag register. It weighs those flags against a per-source enable register and a core-owned master enable, and from that decides two things: whether an interrupt should be taken now, and whether a halted core should be released. A fixed-priority encoder picks which source is serviced.

Software reads and writes the flag and enable registers through a small register port. The core drives master-enable set and clear pulses and reports whether it is halted. When an interrupt is taken, only the winning source's flag is cleared and the master enable drops. The core is released from halt whenever any enabled flag is pending, even when the master enable is off. Some source positions are fixed: the timer-overflow source uses flag bit 2 and the keypad source uses flag bit 4.

Top module: `irq_ctrl`

## Requirements
- R1: A high bit on `irq_req` sets the matching flag at the next clock edge and leaves every other flag unchanged.
- R2: With `reg_sel`=0 the port addresses the flag register. A write replaces flag bits 4..0 with `reg_wdata[4:0]`. Bits 7..5 always read as 1 and ignore writes.
- R3: If a hardware request and a software flag write occur in the same cycle, the requested bit ends up set, whatever value was written to it.
- R4: With `reg_sel`=1 the port addresses the 8-bit enable register. Written values read back unchanged.
- R5: `take` is high in any cycle where the master enable is set and at least one flag is both pending and enabled. In that cycle, `vec` is one-hot on the lowest-numbered such source, with bit 0 having the highest priority. When `take` is low, `vec` is zero.
- R6: When an interrupt is taken, only the winning flag is cleared at the next edge. The other pending flags stay set.
- R7: Taking an interrupt clears the master enable, so `take` lasts exactly one cycle.
- R8: `ime_set` turns the master enable on from the next cycle. If `ime_clr` is high in the same cycle, it wins and the master enable stays off.
- R9: `wake` is high exactly when `halted` is high and any enabled flag is pending, whatever the state of the master enable.
- R10: After synchronous reset (`rst_n` low at an edge), the flag register reads 0xE0, the enable register reads 0x00, the master enable is off, and `take`, `vec` and `wake` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 5 | Per-source request pulses |
| reg_sel | input | 1 | Register select: 0 selects flags, 1 selects enable |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ime_set | input | 1 | Turn master enable on |
| ime_clr | input | 1 | Turn master enable off |
| halted | input | 1 | Core is in halt |
| take | output | 1 | Interrupt accepted this cycle |
| vec | output | 5 | One-hot index of the accepted source |
| wake | output | 1 | Release the core from halt |

## Verification
The bench first sets a single flag, then several flags at once, so that it can confirm the priority encoder picks bit 0 before higher bits and leaves the losing flags pending. It raises a request in the same cycle as a flag write that clears everything, which shows whether hardware or software wins the bit. It pairs a pending flag with an enable that does not match it, which checks that masking blocks both `take` and `wake`. Finally, it drives `ime_set` and `ime_clr` together, which shows which of the two has priority.

// File: rtl/irq_ctrl_pkg.sv
// Shared widths and source positions for the interrupt controller.
// Assumes the register port is one byte wide and the sources occupy the low bits.
package irq_ctrl_pkg;
    localparam int REG_W      = 8;
    localparam int SRC_N      = 5;
    localparam int SRC_TIMER  = 2;
    localparam int SRC_KEYPAD = 4;

    typedef enum logic {
        SEL_FLAGS  = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_t;
endpackage

// File: rtl/irq_ctrl_flags.sv
// Pending-flag register.
// Each bit can be set by a hardware request, replaced by a software write,
// or cleared when its interrupt is taken. Priority from low to high is:
// acceptance clear, then software write, then hardware request.
// Assumes clr_i is zero except in an accept cycle.
module irq_ctrl_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_q;
    logic [N-1:0] flags_nxt;

    // Combine the three update sources in their priority order.
    always_comb begin
        flags_nxt = flags_q & ~clr_i;
        if (wr_i) begin
            flags_nxt = wdata_i;
        end
        flags_nxt = flags_nxt | req_i;
    end

    // Hold the flag state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_nxt;
        end
    end

    assign flags_o = flags_q;

    // R1
    req_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |=> ((flags_o & $past(req_i)) == $past(req_i)));
endmodule

// File: rtl/irq_ctrl_prio.sv
// Fixed-priority encoder: bit 0 has the highest priority.
// Outputs a one-hot vector with the lowest set bit of req_i, or zero.
// The structure is pure combinational logic.
module irq_ctrl_prio #(
    parameter int N = 5
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] win_o
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    // Ripple "a lower bit is set" upward, and grant only the first set bit.
    for (genvar i = 0; i < N; i++) begin : g_stage
        assign win_o[i]  = req_i[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req_i[i];
    end
endmodule

// File: rtl/irq_ctrl.sv
// Interrupt controller top.
// Holds the enable register and the master enable. Decides take and wake,
// and selects the winning source through the priority encoder.
// Assumes the core reacts to take in the same cycle it is raised.
module irq_ctrl
    import irq_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] irq_req,
    input  logic             reg_sel,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             ime_set,
    input  logic             ime_clr,
    input  logic             halted,
    output logic             take,
    output logic [SRC_N-1:0] vec,
    output logic             wake
);
    localparam int PAD_W = REG_W - SRC_N;

    logic [REG_W-1:0] en_q;
    logic             ime_q;
    logic [SRC_N-1:0] flags;
    logic [SRC_N-1:0] pend;
    logic [SRC_N-1:0] win;
    logic             any_pend;
    logic             flag_wr;
    logic             en_wr;

    assign flag_wr = reg_we && (reg_sel_t'(reg_sel) == SEL_FLAGS);
    assign en_wr   = reg_we && (reg_sel_t'(reg_sel) == SEL_ENABLE);

    irq_ctrl_flags #(.N(SRC_N)) flags_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (irq_req),
        .wr_i    (flag_wr),
        .wdata_i (reg_wdata[SRC_N-1:0]),
        .clr_i   (vec),
        .flags_o (flags)
    );

    irq_ctrl_prio #(.N(SRC_N)) prio_i (
        .req_i (pend),
        .win_o (win)
    );

    // Find the serviceable requests and derive take, vec and wake.
    always_comb begin
        pend     = flags & en_q[SRC_N-1:0];
        any_pend = |pend;
        take     = ime_q & any_pend;
        vec      = take ? win : '0;
        wake     = halted & any_pend;
    end

    // Read mux: unused flag bits read as ones.
    always_comb begin
        if (reg_sel_t'(reg_sel) == SEL_ENABLE) begin
            reg_rdata = en_q;
        end else begin
            reg_rdata = {{PAD_W{1'b1}}, flags};
        end
    end

    // Enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= reg_wdata;
        end
    end

    // Master enable: accept or clear wins over set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ime_q <= 1'b0;
        end else if (take || ime_clr) begin
            ime_q <= 1'b0;
        end else if (ime_set) begin
            ime_q <= 1'b1;
        end
    end

    // R5
    vec_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (($countones(vec) == 1) && ((vec & pend) == vec)));

    // R7
    single_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);

    // R6
    winner_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !flag_wr && ((irq_req & vec) == '0)) |=> ((flags & $past(vec)) == '0));

    // R8
    clear_blocks_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ime_clr |=> !take);
endmodule

// File: tb/irq_ctrl_tb_top.sv
// Scoreboard bench: the driver pushes expected accept vectors, and the
// monitor pops and compares them whenever take is seen.
module irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] irq_req;
    logic       reg_sel;
    logic       reg_we;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       ime_set;
    logic       ime_clr;
    logic       halted;
    logic       take;
    logic [4:0] vec;
    logic       wake;

    int checks = 0;
    int errors = 0;
    logic [4:0] exp_q[$];

    always #10 clk = ~clk;

    irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_sel(reg_sel),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ime_set(ime_set), .ime_clr(ime_clr), .halted(halted),
        .take(take), .vec(vec), .wake(wake)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus, driven shortly after the rising edge.
    task automatic step(input logic [4:0] req, input logic we, input logic sel,
                        input logic [7:0] wd, input logic set, input logic clr);
        @(posedge clk);
        #2;
        irq_req = req; reg_we = we; reg_sel = sel; reg_wdata = wd;
        ime_set = set; ime_clr = clr;
    endtask

    task automatic idle();
        step(5'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    // Select a register and compare its read data at the falling edge.
    task automatic rd(input logic sel, input logic [7:0] exp, input string tag);
        step(5'b0, 1'b0, sel, 8'h00, 1'b0, 1'b0);
        @(negedge clk);
        chk(tag, reg_rdata, exp);
    endtask

    // Monitor: every take must match the next queued vector.
    always @(negedge clk) begin
        if (rst_n && take) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5 unexpected take: actual vec %b expected none", vec);
            end else begin
                logic [4:0] e;
                e = exp_q.pop_front();
                if (vec !== e) begin
                    errors++;
                    $display("FAIL R5 vec: actual %b expected %b", vec, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_req = '0; reg_sel = 1'b0; reg_we = 1'b0;
        reg_wdata = '0; ime_set = 1'b0; ime_clr = 1'b0; halted = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R10 reset state
        @(negedge clk);
        chk("R10 take", {7'b0, take}, 8'h00);
        chk("R10 vec", {3'b0, vec}, 8'h00);
        chk("R10 wake", {7'b0, wake}, 8'h00);
        rd(1'b0, 8'hE0, "R10 flags");
        rd(1'b1, 8'h00, "R10 enable");

        // R1 requests accumulate
        step(5'b00100, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        rd(1'b0, 8'hE4, "R1 first request");
        step(5'b00001, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        rd(1'b0, 8'hE5, "R1 second request keeps first");

        // R2 writes replace the low bits; the upper bits stay ones
        step(5'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
        rd(1'b0, 8'hE0, "R2 write zero");
        step(5'b0, 1'b1, 1'b0, 8'h0A, 1'b0, 1'b0);
        rd(1'b0, 8'hEA, "R2 write pattern");

        // R3 a request wins over a clearing write
        step(5'b00010, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
        rd(1'b0, 8'hE2, "R3 request beats write");

        // R4 enable register round trip
        step(5'b0, 1'b1, 1'b1, 8'hA5, 1'b0, 1'b0);
        rd(1'b1, 8'hA5, "R4 enable readback");

        // R9 wake with master enable off
        step(5'b0, 1'b1, 1'b0, 8'h04, 1'b0, 1'b0);
        step(5'b0, 1'b1, 1'b1, 8'h04, 1'b0, 1'b0);
        idle();
        halted = 1'b1;
        @(negedge clk);
        chk("R9 wake while halted", {7'b0, wake}, 8'h01);
        chk("R9 no take", {7'b0, take}, 8'h00);
        #2 halted = 1'b0;
        @(negedge clk);
        chk("R9 no wake when running", {7'b0, wake}, 8'h00);

        // R5 R6 R7 priority and a single-winner clear
        step(5'b0, 1'b1, 1'b0, 8'h0A, 1'b0, 1'b0);
        step(5'b0, 1'b1, 1'b1, 8'h1F, 1'b0, 1'b0);
        exp_q.push_back(5'b00010);
        step(5'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        idle();
        @(negedge clk);
        chk("R7 take high", {7'b0, take}, 8'h01);
        rd(1'b0, 8'hE8, "R6 only winner cleared");
        @(negedge clk);
        chk("R7 no second take", {7'b0, take}, 8'h00);
        exp_q.push_back(5'b01000);
        step(5'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        idle();
        rd(1'b0, 8'hE0, "R6 second winner cleared");

        // R5 masking: a pending flag that is not enabled is ignored
        step(5'b0, 1'b1, 1'b0, 8'h01, 1'b0, 1'b0);
        step(5'b0, 1'b1, 1'b1, 8'h10, 1'b0, 1'b0);
        step(5'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        idle();
        @(negedge clk);
        chk("R5 masked no take", {7'b0, take}, 8'h00);
        halted = 1'b1;
        @(negedge clk);
        chk("R9 masked no wake", {7'b0, wake}, 8'h00);
        halted = 1'b0;
        exp_q.push_back(5'b10000);
        step(5'b10000, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        idle();
        rd(1'b0, 8'hE1, "R6 masked flag stays");

        // R8 clear beats set
        step(5'b0, 1'b1, 1'b1, 8'h01, 1'b0, 1'b0);
        step(5'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
        idle();
        @(negedge clk);
        chk("R8 clear wins", {7'b0, take}, 8'h00);
        exp_q.push_back(5'b00001);
        step(5'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        idle();
        rd(1'b0, 8'hE0, "R8 set then take");

        idle();
        chk("R5 all expected takes seen", exp_q.size()[7:0], 8'h00);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule